// File: doc/BRIEF.md
# Posted-Write Up-Counting Event Timer

This block is a free-running up-counter that raises an overflow event when it steps past all-ones. Software sets a delay by writing the complement of the wanted cycle count as the starting value. In periodic use, that same complemented value also goes into a reload register, so the counter restarts from it after every overflow and produces a steady tick.

Writes to the control, reload and counter registers are posted. Each write is captured in a holding stage and lands in the counting logic a fixed number of cycles later. A status word shows which posted writes are still in flight. The interrupt status, the interrupt enable and the live counter value are read and written without that delay.

The block sits on a simple single-cycle register bus. Writes are strobed by `bus_sel` and `bus_wr`, and reads return data combinationally from `bus_addr`.

Top module: `timer_posted`

## Requirements
- R1: After reset every readable register (addresses 0 to 5) reads zero, `irq` is low and no write is pending.
- R2: A write to CTRL (address 0), LOAD (address 1) or COUNT (address 2) is accepted on its clock edge and takes effect exactly 3 cycles later. From the write edge until that point the matching bit of PEND (address 5) reads 1, and then it clears. The PEND bits are bit 0 for CTRL, bit 1 for LOAD and bit 2 for COUNT.
- R3: A write to CTRL, LOAD or COUNT while that register's PEND bit is set is dropped. The earlier value is the one that lands.
- R4: While the run bit (CTRL bit 0) is 1, the counter rises by one every cycle. Reading COUNT returns the live value with no added delay.
- R5: The counter overflows on a running cycle in which it holds all-ones. Overflow sets STAT bit 0 (address 3). If the counter starts from all-ones minus N, the overflow falls on its (N+1)-th running cycle.
- R6: With the reload bit (CTRL bit 1) at 0, an overflow wraps the counter to zero and clears the run bit.
- R7: With the reload bit at 1, an overflow copies LOAD into the counter and counting continues. If LOAD holds all-ones minus N, overflows repeat every N+1 cycles.
- R8: Once the run bit has been cleared, the counter holds its value.
- R9: Writing 1 to STAT bit 0 clears it and writing 0 leaves it unchanged. An overflow in the same cycle as the clear wins.
- R10: `irq` is a level that is high exactly while STAT bit 0 and IEN bit 0 (address 4) are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timer and bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data |
| irq | output | 1 | Level overflow interrupt |

## Verification
Each posted write lands on the third edge after its write edge. The bench reads the target register and PEND after the second edge, when the old value must still show, and again after the third, when the new value must show. In a one-shot run, the run bit becomes active 3 edges after the CTRL write and the overflow lands N+1 edges after that. STAT is therefore sampled one edge before and at that point. Periodic intervals are measured in posedges between observed overflows and must equal N+1, while STAT, IEN and `irq` are checked on the negative edge that follows the single write edge.

// File: rtl/timer_posted_pkg.sv
package timer_posted_pkg;

    typedef enum logic [2:0] {
        REG_CTRL  = 3'd0,
        REG_LOAD  = 3'd1,
        REG_COUNT = 3'd2,
        REG_STAT  = 3'd3,
        REG_IEN   = 3'd4,
        REG_PEND  = 3'd5
    } reg_addr_e;

    localparam int unsigned NUM_SLOTS = 3;

    typedef struct packed {
        logic reload;
        logic run;
    } ctrl_t;

    function automatic int unsigned lat_bits(input int unsigned lat);
        return (lat < 2) ? 1 : $clog2(lat);
    endfunction

endpackage

// File: rtl/posted_slot.sv
module posted_slot #(
    parameter int unsigned WIDTH    = 32,
    parameter int unsigned SYNC_LAT = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_req,
    input  logic [WIDTH-1:0] wr_data,
    output logic             pend,
    output logic             apply,
    output logic [WIDTH-1:0] hold
);
    import timer_posted_pkg::*;

    localparam int unsigned LAT_W = lat_bits(SYNC_LAT);

    logic [LAT_W-1:0] wait_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend   <= 1'b0;
            wait_q <= '0;
            hold   <= '0;
        end else if (pend) begin
            if (wait_q == '0) begin
                pend <= 1'b0;
            end else begin
                wait_q <= wait_q - 1'b1;
            end
        end else if (wr_req) begin
            pend   <= 1'b1;
            wait_q <= LAT_W'(SYNC_LAT - 1);
            hold   <= wr_data;
        end
    end

    assign apply = pend && (wait_q == '0);

endmodule

// File: rtl/count_core.sv
module count_core #(
    parameter int unsigned CNT_W = 32
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        ctrl_apply,
    input  timer_posted_pkg::ctrl_t     ctrl_data,
    input  logic                        load_apply,
    input  logic [CNT_W-1:0]            load_data,
    input  logic                        cnt_apply,
    input  logic [CNT_W-1:0]            cnt_data,
    output timer_posted_pkg::ctrl_t     ctrl_q,
    output logic [CNT_W-1:0]            load_q,
    output logic [CNT_W-1:0]            count_q,
    output logic                        ovf
);
    assign ovf = ctrl_q.run && (count_q == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (cnt_apply) begin
            count_q <= cnt_data;
        end else if (ovf) begin
            count_q <= ctrl_q.reload ? load_q : '0;
        end else if (ctrl_q.run) begin
            count_q <= count_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            load_q <= '0;
        end else if (load_apply) begin
            load_q <= load_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_apply) begin
            ctrl_q <= ctrl_data;
        end else if (ovf && !ctrl_q.reload) begin
            ctrl_q.run <= 1'b0;
        end
    end

endmodule

// File: rtl/timer_posted.sv
module timer_posted #(
    parameter int unsigned CNT_W    = 32,
    parameter int unsigned SYNC_LAT = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [2:0]       bus_addr,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq
);
    import timer_posted_pkg::*;

    logic                 wr_en;
    logic [NUM_SLOTS-1:0] pend_vec;
    logic [NUM_SLOTS-1:0] apply_vec;
    logic [1:0]           ctrl_hold;
    logic [CNT_W-1:0]     load_hold;
    logic [CNT_W-1:0]     cnt_hold;
    ctrl_t                ctrl_q;
    logic [CNT_W-1:0]     load_q;
    logic [CNT_W-1:0]     count_q;
    logic                 ovf;
    logic                 stat_q;
    logic                 ien_q;

    assign wr_en = bus_sel && bus_wr;

    posted_slot #(.WIDTH(2), .SYNC_LAT(SYNC_LAT)) u_slot_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (wr_en && (bus_addr == REG_CTRL)),
        .wr_data (bus_wdata[1:0]),
        .pend    (pend_vec[0]),
        .apply   (apply_vec[0]),
        .hold    (ctrl_hold)
    );

    posted_slot #(.WIDTH(CNT_W), .SYNC_LAT(SYNC_LAT)) u_slot_load (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (wr_en && (bus_addr == REG_LOAD)),
        .wr_data (bus_wdata),
        .pend    (pend_vec[1]),
        .apply   (apply_vec[1]),
        .hold    (load_hold)
    );

    posted_slot #(.WIDTH(CNT_W), .SYNC_LAT(SYNC_LAT)) u_slot_count (
        .clk     (clk),
        .rst     (rst),
        .wr_req  (wr_en && (bus_addr == REG_COUNT)),
        .wr_data (bus_wdata),
        .pend    (pend_vec[2]),
        .apply   (apply_vec[2]),
        .hold    (cnt_hold)
    );

    count_core #(.CNT_W(CNT_W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .ctrl_apply (apply_vec[0]),
        .ctrl_data  (ctrl_t'(ctrl_hold)),
        .load_apply (apply_vec[1]),
        .load_data  (load_hold),
        .cnt_apply  (apply_vec[2]),
        .cnt_data   (cnt_hold),
        .ctrl_q     (ctrl_q),
        .load_q     (load_q),
        .count_q    (count_q),
        .ovf        (ovf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= 1'b0;
            ien_q  <= 1'b0;
        end else begin
            if (ovf) begin
                stat_q <= 1'b1;
            end else if (wr_en && (bus_addr == REG_STAT) && bus_wdata[0]) begin
                stat_q <= 1'b0;
            end
            if (wr_en && (bus_addr == REG_IEN)) begin
                ien_q <= bus_wdata[0];
            end
        end
    end

    assign irq = stat_q && ien_q;

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_CTRL:  bus_rdata = {{(CNT_W-2){1'b0}}, ctrl_q};
            REG_LOAD:  bus_rdata = load_q;
            REG_COUNT: bus_rdata = count_q;
            REG_STAT:  bus_rdata = {{(CNT_W-1){1'b0}}, stat_q};
            REG_IEN:   bus_rdata = {{(CNT_W-1){1'b0}}, ien_q};
            REG_PEND:  bus_rdata = {{(CNT_W-NUM_SLOTS){1'b0}}, pend_vec};
            default:   bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/timer_posted_chk.sv
module timer_posted_chk #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             run,
    input logic             reload,
    input logic [CNT_W-1:0] count,
    input logic [CNT_W-1:0] load,
    input logic [2:0]       pend,
    input logic             stat,
    input logic             irq,
    input logic             cnt_apply,
    input logic             ctrl_apply
);
    assert_load_lands_R2: assert property (@(posedge clk) disable iff (rst)
        (load != $past(load)) |-> ($past(pend[1]) && !pend[1]));

    assert_count_step_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(run) && !$past(cnt_apply) && ($past(count) != '1))
        |-> (count == $past(count) + 1'b1));

    assert_ovf_flag_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(run) && ($past(count) == '1)) |-> stat);

    assert_oneshot_halt_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(run) && !$past(reload) && ($past(count) == '1) && !$past(ctrl_apply))
        |-> !run);

    assert_stopped_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(run) && !$past(cnt_apply)) |-> $stable(count));

    assert_irq_source_R10: assert property (@(posedge clk) disable iff (rst)
        irq |-> stat);

endmodule

bind timer_posted timer_posted_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .run        (ctrl_q.run),
    .reload     (ctrl_q.reload),
    .count      (count_q),
    .load       (load_q),
    .pend       (pend_vec),
    .stat       (stat_q),
    .irq        (irq),
    .cnt_apply  (apply_vec[2]),
    .ctrl_apply (apply_vec[0])
);

// File: tb/test_timer_posted.sv
module test_timer_posted;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_LOAD  = 3'd1;
    localparam logic [2:0] A_COUNT = 3'd2;
    localparam logic [2:0] A_STAT  = 3'd3;
    localparam logic [2:0] A_IEN   = 3'd4;
    localparam logic [2:0] A_PEND  = 3'd5;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    timer_posted i_timer_posted (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [31:0] v, va, vb;
        int t_prev;
        int seen;

        idle(3);
        rst = 1'b0;
        @(negedge clk);

        // R1: reset state
        for (int a = 0; a < 6; a++) begin
            bus_read(3'(a), v);
            check($sformatf("R1 reg %0d after reset", a), v, 32'd0);
        end
        check("R1 irq after reset", {31'd0, irq}, 32'd0);

        // R2 / R3: posted latency and dropped writes while pending
        bus_write(A_LOAD, 32'h11);
        idle(3);
        bus_write(A_LOAD, 32'hAA);
        bus_read(A_PEND, v);
        check("R2 PEND load bit set", v, 32'd2);
        bus_write(A_LOAD, 32'h55);
        idle(1);
        bus_read(A_LOAD, v);
        check("R2 LOAD old before latency", v, 32'h11);
        bus_read(A_PEND, v);
        check("R2 PEND still set", v, 32'd2);
        idle(1);
        bus_read(A_LOAD, v);
        check("R2 LOAD new after latency", v, 32'hAA);
        bus_read(A_PEND, v);
        check("R2 PEND cleared", v, 32'd0);
        idle(3);
        bus_read(A_LOAD, v);
        check("R3 second write dropped", v, 32'hAA);

        // R5 / R6: one-shot sweep
        bus_write(A_IEN, 32'd1);
        for (int n = 3; n <= 12; n++) begin
            bus_write(A_STAT, 32'd1);
            bus_write(A_COUNT, 32'hFFFF_FFFF - 32'(n));
            idle(3);
            bus_write(A_CTRL, 32'd1);
            idle(n + 3);
            bus_read(A_STAT, v);
            check($sformatf("R5 no overflow yet n=%0d", n), v, 32'd0);
            idle(1);
            bus_read(A_STAT, v);
            check($sformatf("R5 overflow n=%0d", n), v, 32'd1);
            check($sformatf("R10 irq n=%0d", n), {31'd0, irq}, 32'd1);
            bus_read(A_COUNT, v);
            check($sformatf("R6 wrapped n=%0d", n), v, 32'd0);
            bus_read(A_CTRL, v);
            check($sformatf("R6 run cleared n=%0d", n), v, 32'd0);
        end

        // R9 / R10: status clear and enable
        bus_write(A_IEN, 32'd0);
        bus_read(A_STAT, v);
        check("R9 status still set", v, 32'd1);
        check("R10 irq masked", {31'd0, irq}, 32'd0);
        bus_write(A_STAT, 32'd0);
        bus_read(A_STAT, v);
        check("R9 write zero keeps status", v, 32'd1);
        bus_write(A_IEN, 32'd1);
        check("R10 irq on enable", {31'd0, irq}, 32'd1);
        bus_write(A_STAT, 32'd1);
        bus_read(A_STAT, v);
        check("R9 write one clears", v, 32'd0);
        check("R10 irq drops", {31'd0, irq}, 32'd0);

        // R7: periodic reload
        for (int k = 0; k < 3; k++) begin
            int p;
            p = (k == 0) ? 3 : ((k == 1) ? 5 : 9);
            bus_write(A_LOAD, 32'hFFFF_FFFF - 32'(p));
            bus_write(A_COUNT, 32'hFFFF_FFFF - 32'(p));
            bus_write(A_CTRL, 32'd3);
            seen = 0;
            t_prev = 0;
            for (int w = 0; w < 200 && seen < 3; w++) begin
                @(negedge clk);
                if (irq) begin
                    if (seen > 0) check($sformatf("R7 period p=%0d", p), 32'(cyc - t_prev), 32'(p + 1));
                    t_prev = cyc;
                    seen++;
                    bus_write(A_STAT, 32'd1);
                end
            end
            check($sformatf("R7 overflows seen p=%0d", p), 32'(seen), 32'd3);
            bus_write(A_CTRL, 32'd0);
            idle(4);
            bus_write(A_STAT, 32'd1);
            bus_read(A_LOAD, v);
            check($sformatf("R7 load kept p=%0d", p), v, 32'hFFFF_FFFF - 32'(p));
        end

        // R4 / R8: live count and stop
        bus_write(A_COUNT, 32'h1000);
        idle(3);
        bus_write(A_CTRL, 32'd1);
        idle(4);
        bus_read(A_COUNT, va);
        idle(5);
        bus_read(A_COUNT, vb);
        check("R4 live count step", vb - va, 32'd5);
        idle(1);
        bus_write(A_CTRL, 32'd0);
        idle(4);
        bus_read(A_COUNT, va);
        check("R8 stopped value", va, 32'h1000 + 32'd11);
        idle(6);
        bus_read(A_COUNT, vb);
        check("R8 count holds", vb, va);
        bus_read(A_CTRL, v);
        check("R8 run bit cleared", v, 32'd0);

        finish_run();
    end

endmodule